// File: doc/BRIEF.md
# Dual-CPU Interrupt Status and Mask Controller

This block gathers a set of level interrupt sources into one shared status vector and presents it to two processors. Each processor owns its own bank of enable bits. A processor's request line goes high while at least one source is both active and enabled in that processor's bank. The same source can be routed to one processor, to both, or to neither.

Software sees 32-bit words through a plain word-addressed register port. The status words come first, then the words of the first processor's bank, then those of the second processor's bank. Software updates an enable bank by reading a word, changing bits and writing the word back. With 64 sources the two words of each group are stored high half first. A short contiguous run of source positions takes its value from a separate group of external lines, which come from an edge/level front end outside this block.

Top module: `isc_dual_ctrl`

## Requirements
- R1: Reading a status word returns the live value of the sources it holds, with no register stage. Status words can only be read.
- R2: Status positions EXT_LO to EXT_LO+EXT_CNT-1 carry `ext_i[0]` upward. The `src_i` bits at those positions have no effect on status or requests.
- R3: Reset clears both enable banks to zero and drives both request outputs low.
- R4: Each processor's enable bank is written only through its own words. A write to one bank leaves the other bank unchanged, and each word reads back the value last written to it.
- R5: With 64 sources, source n is at word ((n/32) XOR 1), bit (n mod 32), within its group. Word 0 therefore holds sources 32 to 63. The same placement applies to status and to both banks.
- R6: `irq_o[c]` is high in the cycle after a cycle in which (status AND bank c) is nonzero, and low otherwise. It is a register, so it follows a source or enable change one clock later.
- R7: A write to a status word changes neither enable bank, and status still reads back the live sources.
- R8: Word addresses at or beyond 3*(NUM_SRC/32) read as zero, and writes to them are ignored.
- R9: With 32 sources each group is one word: byte offset 0 is status, 4 is processor 0's bank, 8 is processor 1's bank, and 12 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Internal level sources, one per status position |
| ext_i | input | EXT_CNT | External lines placed at positions EXT_LO upward |
| bus_wr_i | input | 1 | Write strobe, takes effect at the clock edge |
| bus_addr_i | input | AW | Byte address; bits [1:0] are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 2 | Registered request line, one per processor |

## Verification
The bench drives every source position one at a time. It checks which word and bit the position shows up in, so a design that forgets to reverse the word order, or that lets `src_i` through inside the external run, gives a wrong read value. For each position it enables the source for only one processor and every other source for the other processor. A design that swaps banks, merges them, or combines them with OR then raises the wrong request line. The bench samples the request line before and after the clock edge to catch a design that has no register stage or an extra one. It writes to status words and to addresses past the map, then reads the banks back, to catch writes that leak through. A second instance with 32 sources checks the one-word layout.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int WORD_BITS = 32;

    typedef enum logic [1:0] {
        RGN_STAT  = 2'd0,
        RGN_MASK0 = 2'd1,
        RGN_MASK1 = 2'd2,
        RGN_NONE  = 2'd3
    } isc_region_e;

    // Bit offset of register word w inside a source vector of 'words' words.
    function automatic int word_base(input int w, input int words);
        return (w ^ (words - 1)) * WORD_BITS;
    endfunction
endpackage

// File: rtl/isc_status_mux.sv
module isc_status_mux #(
    parameter int NUM_SRC = 64,
    parameter int EXT_LO  = 40,
    parameter int EXT_CNT = 6
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [EXT_CNT-1:0] ext_i,
    output logic [NUM_SRC-1:0] stat_o
);
    localparam int EXT_HI = EXT_LO + EXT_CNT - 1;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
        if (n >= EXT_LO && n <= EXT_HI) begin : g_ext
            assign stat_o[n] = ext_i[n - EXT_LO];
        end else begin : g_int
            assign stat_o[n] = src_i[n];
        end
    end

    logic unused_shadowed;
    assign unused_shadowed = &{1'b0, src_i[EXT_LO +: EXT_CNT]};
endmodule

// File: rtl/isc_mask_bank.sv
module isc_mask_bank
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int WSEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [WSEL_W-1:0]  wsel_i,
    input  logic [31:0]        wdata_i,
    output logic [NUM_SRC-1:0] mask_o
);
    localparam int WORDS = NUM_SRC / WORD_BITS;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int BASE = word_base(w, WORDS);
        logic [31:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we_i && wsel_i == WSEL_W'(w)) begin
                word_q <= wdata_i;
            end
        end

        assign mask_o[BASE +: WORD_BITS] = word_q;
    end
endmodule

// File: rtl/isc_req_gen.sv
module isc_req_gen #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               req_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else begin
            req_o <= |(stat_i & mask_i);
        end
    end
endmodule

// File: rtl/isc_dual_ctrl.sv
module isc_dual_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int EXT_LO  = 40,
    parameter int EXT_CNT = 6,
    parameter int AW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [EXT_CNT-1:0] ext_i,
    input  logic               bus_wr_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic [1:0]         irq_o
);
    localparam int WORDS  = NUM_SRC / WORD_BITS;
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [NUM_SRC-1:0] stat_vec;
    logic [NUM_SRC-1:0] mask_q [2];
    logic [NUM_SRC-1:0] mask_c0;
    logic [NUM_SRC-1:0] mask_c1;
    isc_region_e        rgn;
    logic [WSEL_W-1:0]  wsel;
    int                 widx;
    int                 rbase;

    isc_status_mux #(
        .NUM_SRC (NUM_SRC),
        .EXT_LO  (EXT_LO),
        .EXT_CNT (EXT_CNT)
    ) u_stat (
        .src_i  (src_i),
        .ext_i  (ext_i),
        .stat_o (stat_vec)
    );

    // Address decode: status group, then bank 0, then bank 1.
    always_comb begin
        widx = int'(bus_addr_i[AW-1:2]);
        wsel = '0;
        if (widx < WORDS) begin
            rgn  = RGN_STAT;
            wsel = WSEL_W'(widx);
        end else if (widx < 2 * WORDS) begin
            rgn  = RGN_MASK0;
            wsel = WSEL_W'(widx - WORDS);
        end else if (widx < 3 * WORDS) begin
            rgn  = RGN_MASK1;
            wsel = WSEL_W'(widx - 2 * WORDS);
        end else begin
            rgn  = RGN_NONE;
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_cpu
        localparam isc_region_e MY_RGN = (c == 0) ? RGN_MASK0 : RGN_MASK1;

        isc_mask_bank #(
            .NUM_SRC (NUM_SRC),
            .WSEL_W  (WSEL_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bus_wr_i && rgn == MY_RGN),
            .wsel_i  (wsel),
            .wdata_i (bus_wdata_i),
            .mask_o  (mask_q[c])
        );

        isc_req_gen #(
            .NUM_SRC (NUM_SRC)
        ) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .stat_i (stat_vec),
            .mask_i (mask_q[c]),
            .req_o  (irq_o[c])
        );
    end

    assign mask_c0 = mask_q[0];
    assign mask_c1 = mask_q[1];

    always_comb begin
        rbase = word_base(int'(wsel), WORDS);
        unique case (rgn)
            RGN_STAT:  bus_rdata_o = stat_vec[rbase +: WORD_BITS];
            RGN_MASK0: bus_rdata_o = mask_c0[rbase +: WORD_BITS];
            RGN_MASK1: bus_rdata_o = mask_c1[rbase +: WORD_BITS];
            default:   bus_rdata_o = '0;
        endcase
    end

    logic unused_lsb;
    assign unused_lsb = &{1'b0, bus_addr_i[1:0]};
endmodule

// File: rtl/isc_dual_ctrl_chk.sv
module isc_dual_ctrl_chk #(
    parameter int NUM_SRC = 64,
    parameter int EXT_LO  = 40,
    parameter int EXT_CNT = 6,
    parameter int AW      = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_i,
    input logic [AW-1:0]      bus_addr_i,
    input logic [EXT_CNT-1:0] ext_i,
    input logic [1:0]         irq_o,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] m0,
    input logic [NUM_SRC-1:0] m1
);
    localparam int WORDS = NUM_SRC / 32;

    int   word_no;
    logic hits_m0;
    logic hits_m1;

    always_comb begin
        word_no = int'(bus_addr_i >> 2);
        hits_m0 = word_no >= WORDS && word_no < 2 * WORDS;
        hits_m1 = word_no >= 2 * WORDS && word_no < 3 * WORDS;
    end

    assert_banks_clear_R3: assert property (@(posedge clk)
        !rst_n |=> (m0 == '0 && m1 == '0 && irq_o == 2'b00));

    assert_ext_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat[EXT_LO +: EXT_CNT] == ext_i);

    assert_req0_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o[0] == $past(|(stat & m0)));

    assert_req1_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o[1] == $past(|(stat & m1)));

    assert_bank0_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && hits_m0) |=> $stable(m0));

    assert_bank1_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && hits_m1) |=> $stable(m1));

    assert_stat_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && word_no < WORDS) |=> ($stable(m0) && $stable(m1)));
endmodule

bind isc_dual_ctrl isc_dual_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .EXT_LO  (EXT_LO),
    .EXT_CNT (EXT_CNT),
    .AW      (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .ext_i      (ext_i),
    .irq_o      (irq_o),
    .stat       (stat_vec),
    .m0         (mask_c0),
    .m1         (mask_c1)
);

// File: tb/isc_dual_ctrl_test.sv
module isc_dual_ctrl_test;
    localparam int NS  = 64;
    localparam int ELO = 40;
    localparam int ECN = 6;
    localparam int W   = NS / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [5:0]  ext = '0;
    logic [31:0] src32 = '0;
    logic [3:0]  ext32 = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata32;
    logic [1:0]  irq, irq32;
    int          total = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    isc_dual_ctrl #(.NUM_SRC(NS), .EXT_LO(ELO), .EXT_CNT(ECN), .AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .ext_i(ext),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq));

    isc_dual_ctrl #(.NUM_SRC(32), .EXT_LO(8), .EXT_CNT(4), .AW(8)) uut32 (
        .clk(clk), .rst_n(rst_n), .src_i(src32), .ext_i(ext32),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata32), .irq_o(irq32));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 8'(a); wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d, output logic [31:0] d32);
        @(negedge clk);
        addr = 8'(a);
        #1;
        d = rdata; d32 = rdata32;
    endtask

    // Read a 64-bit group starting at word index g, in source order.
    task automatic rd_group(input int g, output logic [63:0] v);
        logic [31:0] lo, hi, x;
        bus_rd((g + 1) * 4, lo, x);   // word 1 = sources 0..31
        bus_rd(g * 4, hi, x);         // word 0 = sources 32..63
        v = {hi, lo};
    endtask

    task automatic wr_group(input int g, input logic [63:0] v);
        bus_wr((g + 1) * 4, v[31:0]);
        bus_wr(g * 4, v[63:32]);
    endtask

    task automatic set_src(input int n, input logic val);
        if (n >= ELO && n < ELO + ECN) ext[n - ELO] = val;
        else src[n] = val;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, exp, m0s, m1s;
        logic [31:0] d, d32;

        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 irq in reset", 64'(irq), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 irq after reset", 64'(irq), 64'd0);
        rd_group(W, v);     chk("R3 bank0 cleared", v, 64'd0);
        rd_group(2 * W, v); chk("R3 bank1 cleared", v, 64'd0);

        // R1 R5 R2: one-hot sweep of internal sources
        for (int n = 0; n < NS; n++) begin
            src = 64'd1 << n; ext = '0;
            bus_rd(((n / 32) ^ 1) * 4, d, d32);
            exp = (n >= ELO && n < ELO + ECN) ? 64'd0 : 64'(32'd1 << (n % 32));
            chk($sformatf("R5 R2 status word for src %0d", n), 64'(d), exp);
            bus_rd(((n / 32)) * 4, d, d32);
            chk($sformatf("R1 other status word for src %0d", n), 64'(d), 64'd0);
        end
        // R2: external lines land in their run
        src = '0;
        for (int k = 0; k < ECN; k++) begin
            ext = 6'(1 << k);
            rd_group(0, v);
            chk($sformatf("R2 ext line %0d", k), v, 64'd1 << (ELO + k));
        end
        ext = '0;

        // R6: per-source routing to one processor only, with latency
        for (int n = 0; n < NS; n++) begin
            int m;
            m = (n + 1) % NS;
            wr_group(W, 64'd1 << n);
            wr_group(2 * W, ~(64'd1 << n));
            set_src(n, 1'b1);
            #1;
            chk($sformatf("R6 no request before edge, src %0d", n), 64'(irq), 64'd0);
            @(negedge clk);
            chk($sformatf("R6 only cpu0, src %0d", n), 64'(irq), 64'd1);
            set_src(m, 1'b1);
            @(negedge clk);
            chk($sformatf("R6 both cpus, src %0d", n), 64'(irq), 64'd3);
            set_src(n, 1'b0); set_src(m, 1'b0);
            #1;
            chk($sformatf("R6 held until edge, src %0d", n), 64'(irq), 64'd3);
            @(negedge clk);
            chk($sformatf("R6 release, src %0d", n), 64'(irq), 64'd0);
        end

        // R2: src_i shadowed inside external run cannot request
        wr_group(W, {64{1'b1}});
        src = 64'd1 << (ELO + 2);
        @(negedge clk); @(negedge clk);
        chk("R2 shadowed src no request", 64'(irq[0]), 64'd0);
        src = '0;

        // R4: bank isolation and readback
        m0s = 64'hA5A5_0F0F_1234_5678;
        m1s = 64'h0FF0_C3C3_8765_4321;
        wr_group(W, m0s);
        wr_group(2 * W, m1s);
        rd_group(W, v);     chk("R4 bank0 readback", v, m0s);
        rd_group(2 * W, v); chk("R4 bank1 readback", v, m1s);
        bus_wr(W * 4, 32'hDEAD_BEEF);
        rd_group(2 * W, v); chk("R4 bank1 untouched by bank0 write", v, m1s);
        rd_group(W, v);     chk("R4 bank0 upper word written", v, {32'hDEAD_BEEF, m0s[31:0]});
        m0s = {32'hDEAD_BEEF, m0s[31:0]};
        bus_wr((2 * W + 1) * 4, 32'h0000_0001);
        rd_group(W, v);     chk("R4 bank0 untouched by bank1 write", v, m0s);
        m1s = {m1s[63:32], 32'h0000_0001};

        // R7: status writes inert
        bus_wr(0, 32'hFFFF_FFFF);
        bus_wr(4, 32'hFFFF_FFFF);
        rd_group(0, v);     chk("R7 status still live", v, 64'd0);
        rd_group(W, v);     chk("R7 bank0 unchanged", v, m0s);
        rd_group(2 * W, v); chk("R7 bank1 unchanged", v, m1s);
        src = 64'h0000_0080_0000_0002;
        rd_group(0, v);     chk("R1 R7 status live after write", v, 64'h0000_0080_0000_0002);
        src = '0;

        // R8: out-of-map addresses
        bus_rd(3 * W * 4, d, d32);       chk("R8 first unmapped read", 64'(d), 64'd0);
        bus_rd(252, d, d32);             chk("R8 last address read", 64'(d), 64'd0);
        bus_wr(3 * W * 4, 32'h5555_5555);
        bus_wr(252, 32'h5555_5555);
        rd_group(W, v);     chk("R8 bank0 unchanged", v, m0s);
        rd_group(2 * W, v); chk("R8 bank1 unchanged", v, m1s);

        // R9: single-word configuration
        bus_wr(4, 32'h8000_0001);
        bus_wr(8, 32'h0000_0F00);
        bus_rd(4, d, d32);  chk("R9 bank0 word", 64'(d32), 64'h8000_0001);
        bus_rd(8, d, d32);  chk("R9 bank1 word", 64'(d32), 64'h0000_0F00);
        bus_rd(12, d, d32); chk("R9 offset 12 zero", 64'(d32), 64'd0);
        src32 = 32'h8000_0200; ext32 = 4'b0001;
        bus_rd(0, d, d32);  chk("R9 R2 status word", 64'(d32), 64'h8000_0100);
        @(negedge clk);
        chk("R9 both requests", 64'(irq32), 64'd3);
        ext32 = '0;
        @(negedge clk);
        chk("R9 cpu0 request only", 64'(irq32), 64'd1);
        src32 = '0;
        @(negedge clk);
        chk("R9 requests released", 64'(irq32), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule